// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block stands between a copy engine's one-cycle completion pulses and the interrupt line, so that software is interrupted once per batch of completions instead of once per completion. It keeps a count of completions not yet acknowledged and the age of that batch, measured in ticks of a fixed period (nominally 20 µs, set in clock cycles by a parameter). In delayed mode the status bit rises as soon as either the count or the age goes past its programmed threshold. In immediate mode every completion raises it at once.

Software programs both thresholds and the mode through one packed configuration register. It acknowledges a batch by writing a one to the status bit, which also empties the pending count and the age. The interrupt line is the status bit gated by a mask bit. A small register port with a selector writes and reads the configuration word, the status word and the mask word.

Top module: `coal_intr_coalescer`

## Requirements
- R1: After reset the status, the mask and the interrupt are 0, the pending count and age read 0, and the configuration word reads `CFG_RESET` (default 0x9414: delayed mode on, both thresholds 20).
- R2: Selector 0 is the configuration word. Bit 15 turns on delayed mode, bits [14:8] hold the count threshold and bits [6:0] hold the age threshold. Every other bit reads 0.
- R3: In delayed mode the status sets on the clock edge after the one at which the pending count becomes larger than the count threshold. It then stays set until it is cleared.
- R4: The age goes up by one on each tick (one tick every `TICK_CYCLES` clocks, counted from reset) while the pending count is nonzero, and it saturates at 127. In delayed mode the status sets on the edge after the age becomes larger than the age threshold.
- R5: In delayed mode, a threshold of 0 makes its criterion fire on the first pending completion.
- R6: With bit 15 at 0, each completion pulse sets the status on the same edge and both thresholds have no effect.
- R7: A write to selector 1 with bit 16 at 1 clears the status, the pending count and the age, and in delayed mode it wins over a set in that cycle. A write to selector 1 with bit 16 at 0 changes nothing.
- R8: A completion that arrives in the same cycle as a clear leaves the pending count at 1. In immediate mode it also leaves the status set.
- R9: The pending count saturates at 127 and does not wrap.
- R10: Selector 2 is the mask word, with its flag in bit 16. The interrupt equals the status AND the mask bit.
- R11: Reading selector 1 gives the status in bit 16, the age in [14:8] and the pending count in [6:0]. Writes to selector 3 are ignored and reads of selector 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpl_pulse | input | 1 | One completion per cycle in which it is high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Write target: 0 config, 1 status, 2 mask, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Read selector, same encoding as reg_sel |
| reg_rdata | output | 32 | Read data for reg_rsel, combinational |
| coal_status | output | 1 | Coalesced done status |
| irq | output | 1 | Status gated by the mask bit |

## Verification
The assertions assume that the completion input counts at most one completion per cycle and that a clear is a single-cycle write strobe. They also assume that configuration changes take effect from the next cycle, so the status decision in the cycle of a configuration write still uses the old thresholds. The stimulus drives every input only between clock edges, mixes directed sequences with random pulse trains, clears and configuration writes, and keeps the random thresholds small enough that both criteria fire often within the run.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // Bit that carries the status flag, the mask flag and the clear request
   localparam int unsigned STAT_BIT = 16;

   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/coal_ticker.sv
module coal_ticker #(
   parameter int unsigned TICK_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

   logic [CW-1:0] div_q;

   assign tick = (div_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (tick) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   // R4: ticks are isolated single-cycle events
   a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/coal_tracker.sv
module coal_tracker #(
   parameter int unsigned FIELD_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pulse,
   input  logic               clr,
   input  logic               tick,
   output logic [FIELD_W-1:0] pend,
   output logic [FIELD_W-1:0] age
);
   localparam logic [FIELD_W-1:0] TOP = '1;

   logic pend_full, age_full, busy;

   assign pend_full = (pend == TOP);
   assign age_full  = (age == TOP);
   assign busy      = (pend != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         age  <= '0;
      end else if (clr) begin
         pend <= {{(FIELD_W-1){1'b0}}, pulse};
         age  <= '0;
      end else begin
         if (pulse && !pend_full)        pend <= pend + 1'b1;
         if (tick && busy && !age_full)  age  <= age + 1'b1;
      end
   end

   // R9: the pending count holds at its ceiling
   a_r9_pend_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_full && !clr) |=> (pend == TOP));

   // R4: the age never jumps by more than one step
   a_r4_age_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((age == $past(age)) || (age == $past(age) + 1'b1)));

   // R7: a clear empties the age
   a_r7_age_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (age == '0));
endmodule

// File: rtl/coal_regfile.sv
module coal_regfile
   import coal_pkg::*;
#(
   parameter int unsigned FIELD_W   = 7,
   parameter logic [31:0] CFG_RESET = 32'h0000_9414
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [31:0]        wr_data,
   input  logic [1:0]         rd_sel,
   input  logic               status,
   input  logic [FIELD_W-1:0] pend,
   input  logic [FIELD_W-1:0] age,
   output logic               dly_en,
   output logic [FIELD_W-1:0] cnt_thr,
   output logic [FIELD_W-1:0] time_thr,
   output logic               mask_on,
   output logic               clr,
   output logic [31:0]        rd_data
);
   localparam int unsigned CNT_LO = FIELD_W + 1;
   localparam int unsigned EN_BIT = 2 * FIELD_W + 1;

   reg_sel_e wsel, rsel;
   logic     unused_wbits;

   assign wsel         = reg_sel_e'(wr_sel);
   assign rsel         = reg_sel_e'(rd_sel);
   assign unused_wbits = ^wr_data;
   assign clr          = wr_en && (wsel == SEL_STAT) && wr_data[STAT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_en   <= CFG_RESET[EN_BIT];
         cnt_thr  <= CFG_RESET[CNT_LO +: FIELD_W];
         time_thr <= CFG_RESET[0 +: FIELD_W];
         mask_on  <= 1'b0;
      end else if (wr_en) begin
         if (wsel == SEL_CFG) begin
            dly_en   <= wr_data[EN_BIT];
            cnt_thr  <= wr_data[CNT_LO +: FIELD_W];
            time_thr <= wr_data[0 +: FIELD_W];
         end
         if (wsel == SEL_MASK) mask_on <= wr_data[STAT_BIT];
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rsel)
         SEL_CFG: begin
            rd_data[EN_BIT]            = dly_en;
            rd_data[CNT_LO +: FIELD_W] = cnt_thr;
            rd_data[0 +: FIELD_W]      = time_thr;
         end
         SEL_STAT: begin
            rd_data[STAT_BIT]          = status;
            rd_data[CNT_LO +: FIELD_W] = age;
            rd_data[0 +: FIELD_W]      = pend;
         end
         SEL_MASK: rd_data[STAT_BIT]   = mask_on;
         default:  rd_data             = '0;
      endcase
   end

   // R11: a write to the empty selector leaves the configuration alone
   a_r11_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel == SEL_NONE) |=> ($stable(cnt_thr) && $stable(time_thr)
                                       && $stable(dly_en) && $stable(mask_on)));
endmodule

// File: rtl/coal_intr_coalescer.sv
module coal_intr_coalescer
   import coal_pkg::*;
#(
   parameter int unsigned FIELD_W     = 7,
   parameter int unsigned TICK_CYCLES = 2000,
   parameter logic [31:0] CFG_RESET   = 32'h0000_9414
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmpl_pulse,
   input  logic        reg_wr,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   input  logic [1:0]  reg_rsel,
   output logic [31:0] reg_rdata,
   output logic        coal_status,
   output logic        irq
);
   localparam int unsigned EN_BIT = 2 * FIELD_W + 1;

   generate
      if (EN_BIT >= STAT_BIT) begin : g_bad_field
         $error("FIELD_W too wide: configuration fields reach the status bit");
      end
      if (TICK_CYCLES < 2) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 2");
      end
   endgenerate

   logic               tick, clr, dly_en, mask_on;
   logic [FIELD_W-1:0] cnt_thr, time_thr, pend, age;
   logic               bypass_set, count_hit, age_hit, delay_hit;

   coal_ticker #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   coal_tracker #(.FIELD_W(FIELD_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (cmpl_pulse),
      .clr   (clr),
      .tick  (tick),
      .pend  (pend),
      .age   (age)
   );

   coal_regfile #(.FIELD_W(FIELD_W), .CFG_RESET(CFG_RESET)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_sel   (reg_sel),
      .wr_data  (reg_wdata),
      .rd_sel   (reg_rsel),
      .status   (coal_status),
      .pend     (pend),
      .age      (age),
      .dly_en   (dly_en),
      .cnt_thr  (cnt_thr),
      .time_thr (time_thr),
      .mask_on  (mask_on),
      .clr      (clr),
      .rd_data  (reg_rdata)
   );

   assign bypass_set = !dly_en && cmpl_pulse;
   assign count_hit  = pend > cnt_thr;
   assign age_hit    = (pend != '0) && ((time_thr == '0) || (age > time_thr));
   assign delay_hit  = dly_en && (count_hit || age_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   coal_status <= 1'b0;
      else if (clr) coal_status <= bypass_set;
      else          coal_status <= coal_status | delay_hit | bypass_set;
   end

   assign irq = coal_status & mask_on;

   // R6: immediate mode raises the status on the pulse edge
   a_r6_bypass_sets: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_set |=> coal_status);

   // R3: the status is sticky until a clear
   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (coal_status && !clr) |=> coal_status);

   // R7: in delayed mode a clear wins over any set in its cycle
   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && dly_en) |=> !coal_status);

   // R5: a zero count threshold fires on any pending completion
   a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_en && cnt_thr == '0 && pend != '0 && !clr) |=> coal_status);
endmodule

// File: tb/coal_intr_coalescer_tb_top.sv
module coal_intr_coalescer_tb_top;
   localparam int TICK = 8;
   localparam int SAT  = 127;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmpl_pulse = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_rsel = '0;
   logic [31:0] reg_rdata;
   logic        coal_status, irq;

   always #5 clk = ~clk;

   coal_intr_coalescer #(.FIELD_W(7), .TICK_CYCLES(TICK), .CFG_RESET(32'h0000_9414)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
      .reg_rdata(reg_rdata), .coal_status(coal_status), .irq(irq)
   );

   // reference state
   int m_pend, m_age, m_st, m_tick, m_den, m_cthr, m_tthr, m_mask;
   int vecs = 0, miss = 0;
   string req = "R1";

   function automatic int exp_rd(int s);
      case (s)
         0: return (m_den << 15) | (m_cthr << 8) | m_tthr;
         1: return (m_st << 16) | (m_age << 8) | m_pend;
         2: return m_mask << 16;
         default: return 0;
      endcase
   endfunction

   task automatic compare();
      int er;
      er = exp_rd(int'(reg_rsel));
      vecs++;
      if (coal_status !== m_st[0]) begin
         miss++;
         $display("FAIL %s status actual %0b expected %0b", req, coal_status, m_st[0]);
      end
      if (irq !== (m_st[0] & m_mask[0])) begin
         miss++;
         $display("FAIL %s irq actual %0b expected %0b", req, irq, m_st[0] & m_mask[0]);
      end
      if (reg_rdata !== 32'(er)) begin
         miss++;
         $display("FAIL %s rdata(sel %0d) actual %h expected %h", req, reg_rsel, reg_rdata, 32'(er));
      end
   endtask

   task automatic step(input bit p, input bit we, input int s, input logic [31:0] d);
      bit tk, clr, byp, hit;
      cmpl_pulse = p; reg_wr = we; reg_sel = s[1:0]; reg_wdata = d;
      reg_rsel   = 2'(vecs % 4);
      tk  = (m_tick == TICK - 1);
      clr = we && (s == 1) && d[16];
      byp = (m_den == 0) && p;
      hit = (m_den != 0) && (m_pend > m_cthr ||
            (m_pend > 0 && (m_tthr == 0 || m_age > m_tthr)));
      @(posedge clk);
      if (clr) begin
         m_st = byp; m_pend = p; m_age = 0;
      end else begin
         m_st = (m_st != 0 || hit || byp) ? 1 : 0;
         if (tk && m_pend > 0 && m_age < SAT) m_age++;
         if (p && m_pend < SAT) m_pend++;
      end
      if (we && s == 0) begin
         m_den = d[15]; m_cthr = int'(d[14:8]); m_tthr = int'(d[6:0]);
      end
      if (we && s == 2) m_mask = d[16];
      m_tick = tk ? 0 : m_tick + 1;
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      repeat (n) step(0, 0, 0, 32'h0);
   endtask

   task automatic wr(input int s, input logic [31:0] d);
      step(0, 1, s, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miss++;
      $display("FAIL watchdog expired in %s", req);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      m_pend = 0; m_age = 0; m_st = 0; m_tick = 0;
      m_den = 1; m_cthr = 20; m_tthr = 20; m_mask = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values on every selector
      req = "R1";
      for (int s = 0; s < 4; s++) begin
         reg_rsel = 2'(s); #1; compare();
      end
      idle(4);

      // R2: field layout, unused bits read 0
      req = "R2";
      wr(0, 32'hFFFF_FFFF);
      idle(4);
      // R11: empty selector write ignored, reads 0
      req = "R11";
      wr(3, 32'hFFFF_FFFF);
      idle(4);

      // R10: mask on
      req = "R10";
      wr(2, 32'h0001_0000);
      idle(3);

      // R3: count threshold 3, long age threshold
      req = "R3";
      wr(0, 32'h0000_8000 | (3 << 8) | 100);
      wr(1, 32'h0001_0000);
      repeat (4) begin step(1, 0, 0, 0); idle(1); end
      idle(4);

      // R7: clear, and a write with bit 16 low changes nothing
      req = "R7";
      wr(1, 32'h0000_FFFF);
      idle(2);
      wr(1, 32'h0001_0000);
      idle(3);

      // R8: clear with a coinciding pulse in delayed mode, count threshold 0
      req = "R8";
      wr(0, 32'h0000_8000 | (0 << 8) | 100);
      step(1, 1, 1, 32'h0001_0000);
      idle(3);

      // R4: age threshold 2, count threshold high
      req = "R4";
      wr(0, 32'h0000_8000 | (100 << 8) | 2);
      wr(1, 32'h0001_0000);
      step(1, 0, 0, 0);
      idle(45);

      // R5: age threshold 0 fires on first pending
      req = "R5";
      wr(0, 32'h0000_8000 | (100 << 8) | 0);
      wr(1, 32'h0001_0000);
      idle(5);
      step(1, 0, 0, 0);
      idle(3);

      // R6: immediate mode, thresholds ignored
      req = "R6";
      wr(0, 32'h0000_0000 | (100 << 8) | 100);
      wr(1, 32'h0001_0000);
      idle(3);
      step(1, 0, 0, 0);
      idle(2);
      // R8: clear with pulse in immediate mode keeps status
      req = "R8";
      step(1, 1, 1, 32'h0001_0000);
      idle(2);

      // R9: saturation of the pending count
      req = "R9";
      wr(0, 32'h0000_8000 | (127 << 8) | 127);
      wr(1, 32'h0001_0000);
      repeat (140) step(1, 0, 0, 0);
      idle(4);

      // R10: mask off gates the interrupt
      req = "R10";
      wr(0, 32'h0000_8000);
      step(1, 0, 0, 0);
      idle(2);
      wr(2, 32'h0000_0000);
      idle(3);

      // mixed random traffic
      req = "R3";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 2)      wr(0, $urandom & 32'h0000_8707);
         else if (r < 4) wr(2, $urandom & 32'h0001_0000);
         else if (r < 8) step(($urandom % 2) == 1, 1, 1, 32'h0001_0000);
         else            step(($urandom % 3) == 0, 0, 0, 32'h0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule